// File: doc/BRIEF.md
# UART Host Register Interface

This block is the processor-side register bank of a serial port. A host reaches eight byte-wide locations through a 3-bit address, a chip select, and separate read and write strobes. Each strobe is sampled as a one-cycle pulse on the rising edge of the clock. The bank holds the line settings, the FIFO settings, a scratch byte, a 4-bit interrupt-enable field and a 16-bit baud divisor.

The line and FIFO settings are driven straight out to the transmitter and receiver. Accesses to the data location become a push strobe toward the transmit FIFO and a pop strobe toward the receive FIFO. Reads of the status location combine live FIFO and transmitter levels with sticky receive error flags.

A divider built from the system clock produces the 16x oversampling tick. One address pair is shared: when the divisor-access bit of the line settings is set, the first two locations reach the divisor bytes in place of the data port and interrupt enable.

Top module: `uart_host_regs`

## Requirements
- R1: Line settings (address 3) and scratch (address 7) read back what was last written. Address 2 always reads 0x01. Addresses 4 and 6 read 0x00, and writes to them are ignored.
- R2: While line settings bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 the divisor high byte. Neither address then asserts `tx_push_o` or `rx_pop_o`, and neither touches the interrupt-enable field.
- R3: While line settings bit 7 is 0, a write to address 0 asserts `tx_push_o` for that strobe cycle, with `tx_data_o` equal to the write data. A read of address 0 returns `rx_data_i` and asserts `rx_pop_o` for that cycle. Without chip select, `rdata_o` is 0x00 and no strobe is issued.
- R4: The line settings fields drive the outputs as follows: bits 1:0 `word_len_o` (00 = 5 bits, 11 = 8 bits), bit 2 `stop_long_o`, bit 3 `parity_en_o`, bit 4 `parity_even_o`, bit 5 `parity_stick_o`, bit 6 `break_o`.
- R5: A write to address 2 sets `fifo_en_o` from bit 0 and `dma_mode_o` from bit 3. Bits 7:6 select `rx_trig_level_o` as 00 = 1, 01 = 4, 10 = 8, 11 = 14.
- R6: A write to address 2 with bit 1 set makes `rx_fifo_rst_o` high for exactly the one cycle after the write edge. Bit 2 does the same for `tx_fifo_rst_o`. Neither bit is held.
- R7: After a divisor byte is written, `baud_tick_o` is low, then first goes high one-cycle wide D cycles after that write edge, and repeats every D cycles, where D is the divisor. With D = 1 the tick is high every cycle.
- R8: A divisor of zero keeps `baud_tick_o` low.
- R9: The status byte at address 5 is built, from bit 7 down to bit 0, as `rx_fifo_err_i`, `tx_idle_i`, `tx_hold_empty_i`, sticky break, sticky framing, sticky parity, sticky overrun, and not `rx_empty_i`. Each sticky flag is set by a one-cycle pulse on its event input.
- R10: A status read clears the four sticky flags after returning them. An event that arrives in the same cycle as the read survives it.
- R11: After reset, all stored registers and the divisor are zero, no tick is produced, and the status reads 0x60 with the transmit side idle and the receive FIFO empty.
- R12: While line settings bit 7 is 0, address 1 stores write data bits 3:0 and reads them back with bits 7:4 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while cs_i and rd_i are high |
| tx_push_o | output | 1 | Push strobe toward the transmit FIFO |
| tx_data_o | output | 8 | Byte to push |
| rx_pop_o | output | 1 | Pop strobe toward the receive FIFO |
| rx_data_i | input | 8 | Head byte of the receive FIFO |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_fifo_err_i | input | 1 | Some byte in the receive FIFO carries an error |
| tx_hold_empty_i | input | 1 | Transmit FIFO empty |
| tx_idle_i | input | 1 | Transmit FIFO and shifter both empty |
| rx_ovr_i | input | 1 | Overrun event pulse |
| rx_perr_i | input | 1 | Parity error event pulse |
| rx_ferr_i | input | 1 | Framing error event pulse |
| rx_brk_i | input | 1 | Break detected event pulse |
| word_len_o | output | 2 | Character length code |
| stop_long_o | output | 1 | Long stop period select |
| parity_en_o | output | 1 | Parity enable |
| parity_even_o | output | 1 | Even parity select |
| parity_stick_o | output | 1 | Forced parity value select |
| break_o | output | 1 | Force the serial output low |
| fifo_en_o | output | 1 | FIFO mode enable |
| dma_mode_o | output | 1 | DMA signalling mode |
| rx_trig_level_o | output | 4 | Receive trigger level in bytes |
| rx_fifo_rst_o | output | 1 | One-cycle receive FIFO reset |
| tx_fifo_rst_o | output | 1 | One-cycle transmit FIFO reset |
| baud_tick_o | output | 1 | 16x oversampling tick |

## Verification
The properties assume that the host presents each access as a single-cycle strobe, and that read and write are never raised together. They also assume that the receiver raises each error event as an isolated one-cycle pulse. The bench meets these assumptions because every access and every event comes from a task. Each task raises its signals on a falling edge, holds them across exactly one rising edge, and drops them on the next falling edge. It never overlaps two tasks, except in the one scenario that deliberately places an event on the same cycle as a status read. The divisor is always written while no other access is pending, so each reload is separated from the next.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = 2 * BYTE_W;
  localparam int NFLAG  = 4;

  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_FIFO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LINE  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_MSTAT = 3'd6;
  localparam logic [ADDR_W-1:0] A_SCR   = 3'd7;

  localparam logic [BYTE_W-1:0] ID_IDLE = 8'h01;

  typedef struct packed {
    logic       div_access;
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop_long;
    logic [1:0] wlen;
  } line_ctl_t;

  function automatic logic [3:0] trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_bytes = 4'd1;
      2'd1:    trig_bytes = 4'd4;
      2'd2:    trig_bytes = 4'd8;
      default: trig_bytes = 4'd14;
    endcase
  endfunction
endpackage

// File: rtl/uart_host_decode.sv
module uart_host_decode
  import uart_host_pkg::*;
(
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dlab_i,
  output logic              wr_thr_o,
  output logic              wr_ien_o,
  output logic              wr_dll_o,
  output logic              wr_dlm_o,
  output logic              wr_fcr_o,
  output logic              wr_lcr_o,
  output logic              wr_scr_o,
  output logic              rd_rbr_o,
  output logic              rd_lsr_o
);
  logic wr_en, rd_en;

  assign wr_en = cs_i & wr_i;
  assign rd_en = cs_i & rd_i;

  assign wr_thr_o = wr_en & (addr_i == A_DATA) & ~dlab_i;
  assign wr_dll_o = wr_en & (addr_i == A_DATA) &  dlab_i;
  assign wr_ien_o = wr_en & (addr_i == A_IEN)  & ~dlab_i;
  assign wr_dlm_o = wr_en & (addr_i == A_IEN)  &  dlab_i;
  assign wr_fcr_o = wr_en & (addr_i == A_FIFO);
  assign wr_lcr_o = wr_en & (addr_i == A_LINE);
  assign wr_scr_o = wr_en & (addr_i == A_SCR);
  assign rd_rbr_o = rd_en & (addr_i == A_DATA) & ~dlab_i;
  assign rd_lsr_o = rd_en & (addr_i == A_STAT);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         tick_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      tick_q <= 1'b0;
    end else if (div_i == '0) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q <= ONE) begin
      cnt_q  <= div_i;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - ONE;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/uart_lsr_flags.sv
module uart_lsr_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clear_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  // set wins over a clear in the same cycle
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flags_q[i] <= 1'b0;
      else if (set_i[i])   flags_q[i] <= 1'b1;
      else if (clear_i)    flags_q[i] <= 1'b0;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              tx_push_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              rx_pop_o,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_empty_i,
  input  logic              rx_fifo_err_i,
  input  logic              tx_hold_empty_i,
  input  logic              tx_idle_i,
  input  logic              rx_ovr_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  output logic [1:0]        word_len_o,
  output logic              stop_long_o,
  output logic              parity_en_o,
  output logic              parity_even_o,
  output logic              parity_stick_o,
  output logic              break_o,
  output logic              fifo_en_o,
  output logic              dma_mode_o,
  output logic [3:0]        rx_trig_level_o,
  output logic              rx_fifo_rst_o,
  output logic              tx_fifo_rst_o,
  output logic              baud_tick_o
);
  line_ctl_t         lcr_q;
  logic [BYTE_W-1:0] scr_q, dll_q, dlm_q;
  logic [3:0]        ien_q;
  logic              fen_q, dma_q;
  logic [1:0]        trig_q;
  logic              rx_rst_q, tx_rst_q;
  logic [DIV_W-1:0]  div_q, div_nxt;
  logic [NFLAG-1:0]  sticky_q;
  logic [BYTE_W-1:0] lsr;

  logic wr_thr, wr_ien, wr_dll, wr_dlm, wr_fcr, wr_lcr, wr_scr, rd_rbr, rd_lsr;

  uart_host_decode u_dec (
    .cs_i     (cs_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .dlab_i   (lcr_q.div_access),
    .wr_thr_o (wr_thr),
    .wr_ien_o (wr_ien),
    .wr_dll_o (wr_dll),
    .wr_dlm_o (wr_dlm),
    .wr_fcr_o (wr_fcr),
    .wr_lcr_o (wr_lcr),
    .wr_scr_o (wr_scr),
    .rd_rbr_o (rd_rbr),
    .rd_lsr_o (rd_lsr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q    <= '0;
      scr_q    <= '0;
      dll_q    <= '0;
      dlm_q    <= '0;
      ien_q    <= '0;
      fen_q    <= 1'b0;
      dma_q    <= 1'b0;
      trig_q   <= '0;
      rx_rst_q <= 1'b0;
      tx_rst_q <= 1'b0;
    end else begin
      if (wr_lcr) lcr_q <= line_ctl_t'(wdata_i);
      if (wr_scr) scr_q <= wdata_i;
      if (wr_dll) dll_q <= wdata_i;
      if (wr_dlm) dlm_q <= wdata_i;
      if (wr_ien) ien_q <= wdata_i[3:0];
      if (wr_fcr) begin
        fen_q  <= wdata_i[0];
        dma_q  <= wdata_i[3];
        trig_q <= wdata_i[7:6];
      end
      rx_rst_q <= wr_fcr & wdata_i[1];
      tx_rst_q <= wr_fcr & wdata_i[2];
    end
  end

  assign div_q   = {dlm_q, dll_q};
  assign div_nxt = {wr_dlm ? wdata_i : dlm_q, wr_dll ? wdata_i : dll_q};

  uart_baud_gen #(.W(DIV_W)) u_baud (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_i      (div_q),
    .load_i     (wr_dll | wr_dlm),
    .load_val_i (div_nxt),
    .tick_o     (baud_tick_o)
  );

  uart_lsr_flags #(.N(NFLAG)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   ({rx_brk_i, rx_ferr_i, rx_perr_i, rx_ovr_i}),
    .clear_i (rd_lsr),
    .flags_o (sticky_q)
  );

  assign lsr = {rx_fifo_err_i, tx_idle_i, tx_hold_empty_i, sticky_q, ~rx_empty_i};

  always_comb begin
    rdata_o = '0;
    if (cs_i && rd_i) begin
      case (addr_i)
        A_DATA:  rdata_o = lcr_q.div_access ? dll_q : rx_data_i;
        A_IEN:   rdata_o = lcr_q.div_access ? dlm_q : {4'b0, ien_q};
        A_FIFO:  rdata_o = ID_IDLE;
        A_LINE:  rdata_o = lcr_q;
        A_STAT:  rdata_o = lsr;
        A_SCR:   rdata_o = scr_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign tx_push_o       = wr_thr;
  assign tx_data_o       = wdata_i;
  assign rx_pop_o        = rd_rbr;
  assign word_len_o      = lcr_q.wlen;
  assign stop_long_o     = lcr_q.stop_long;
  assign parity_en_o     = lcr_q.par_en;
  assign parity_even_o   = lcr_q.even;
  assign parity_stick_o  = lcr_q.stick;
  assign break_o         = lcr_q.brk;
  assign fifo_en_o       = fen_q;
  assign dma_mode_o      = dma_q;
  assign rx_trig_level_o = trig_bytes(trig_q);
  assign rx_fifo_rst_o   = rx_rst_q;
  assign tx_fifo_rst_o   = tx_rst_q;
endmodule

// File: rtl/uart_host_sva.sv
module uart_host_sva
  import uart_host_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        rst_bits_i,
  input logic [NFLAG-1:0]  evt_i,
  input logic [NFLAG-1:0]  flags_i,
  input logic [DIV_W-1:0]  div_i,
  input logic              tick_i,
  input logic              rx_rst_i,
  input logic              tx_rst_i
);
  p_rx_rst_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_i |-> $past(cs_i && wr_i && addr_i == A_FIFO && rst_bits_i[0]));

  p_tx_rst_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst_i |-> $past(cs_i && wr_i && addr_i == A_FIFO && rst_bits_i[1]));

  p_tick_narrow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && div_i != DIV_W'(1)) |=> !tick_i);

  p_zero_div_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == '0 && $past(div_i) == '0) |-> !tick_i);

  p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags_i & $past(evt_i)) == $past(evt_i)));

  p_flag_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == A_STAT && evt_i == '0) |=> flags_i == '0);
endmodule

bind uart_host_regs uart_host_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .rst_bits_i (wdata_i[2:1]),
  .evt_i      ({rx_brk_i, rx_ferr_i, rx_perr_i, rx_ovr_i}),
  .flags_i    (sticky_q),
  .div_i      (div_q),
  .tick_i     (baud_tick_o),
  .rx_rst_i   (rx_fifo_rst_o),
  .tx_rst_i   (tx_fifo_rst_o)
);

// File: tb/tb_uart_host_regs.sv
`timescale 1ns/1ps
module tb_uart_host_regs;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 0, rd_i = 0, wr_i = 0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, tx_data_o;
  logic       tx_push_o, rx_pop_o;
  logic [7:0] rx_data_i = 8'hA5;
  logic       rx_empty_i = 1, rx_fifo_err_i = 0, tx_hold_empty_i = 1, tx_idle_i = 1;
  logic       rx_ovr_i = 0, rx_perr_i = 0, rx_ferr_i = 0, rx_brk_i = 0;
  logic [1:0] word_len_o;
  logic       stop_long_o, parity_en_o, parity_even_o, parity_stick_o, break_o;
  logic       fifo_en_o, dma_mode_o, rx_fifo_rst_o, tx_fifo_rst_o, baud_tick_o;
  logic [3:0] rx_trig_level_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  uart_host_regs dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic       last_push;
  logic [7:0] last_txd;

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    #1;
    last_push = tx_push_o;
    last_txd  = tx_data_o;
    @(posedge clk_i);
    @(negedge clk_i);
    cs_i = 0; wr_i = 0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d, output logic pop);
    @(negedge clk_i);
    cs_i = 1; rd_i = 1; addr_i = a;
    #1;
    d = rdata_o;
    pop = rx_pop_o;
    @(posedge clk_i);
    @(negedge clk_i);
    cs_i = 0; rd_i = 0;
  endtask

  task automatic pulse_evt(input logic [3:0] e);
    @(negedge clk_i);
    {rx_brk_i, rx_ferr_i, rx_perr_i, rx_ovr_i} = e;
    @(posedge clk_i);
    @(negedge clk_i);
    {rx_brk_i, rx_ferr_i, rx_perr_i, rx_ovr_i} = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic p;
    do_read(3'd5, d, p); check("R11 status after reset", d, 8'h60);
    do_read(3'd3, d, p); check("R11 line settings after reset", d, 8'h00);
    do_read(3'd7, d, p); check("R11 scratch after reset", d, 8'h00);
    check("R11 trigger after reset", rx_trig_level_o, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      check("R11 no tick after reset", baud_tick_o, 0);
    end
  endtask

  task automatic t_map;
    logic [7:0] d; logic p;
    do_write(3'd3, 8'h1B); do_read(3'd3, d, p); check("R1 line settings readback", d, 8'h1B);
    do_write(3'd7, 8'h5A); do_read(3'd7, d, p); check("R1 scratch readback", d, 8'h5A);
    do_read(3'd2, d, p); check("R1 id reads no pending", d, 8'h01);
    do_write(3'd4, 8'hFF); do_read(3'd4, d, p); check("R1 modem control reads zero", d, 8'h00);
    do_read(3'd6, d, p); check("R1 modem status reads zero", d, 8'h00);
  endtask

  task automatic t_line;
    do_write(3'd3, 8'h7D);
    check("R4 field outputs",
          {word_len_o, stop_long_o, parity_en_o, parity_even_o, parity_stick_o, break_o},
          {2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1});
    do_write(3'd3, 8'h03);
    check("R4 field outputs 8N1",
          {word_len_o, stop_long_o, parity_en_o, parity_even_o, parity_stick_o, break_o},
          {2'b11, 5'b0});
  endtask

  task automatic t_ien;
    logic [7:0] d; logic p;
    do_write(3'd1, 8'hFF); do_read(3'd1, d, p); check("R12 enable field readback", d, 8'h0F);
  endtask

  task automatic t_data;
    logic [7:0] d; logic p;
    do_write(3'd0, 8'h3C);
    check("R3 push on data write", last_push, 1);
    check("R3 pushed byte", last_txd, 8'h3C);
    do_read(3'd0, d, p);
    check("R3 receive byte", d, 8'hA5);
    check("R3 pop on data read", p, 1);
    @(negedge clk_i);
    rd_i = 1; addr_i = 3'd0; #1;
    check("R3 no data without select", rdata_o, 0);
    check("R3 no pop without select", rx_pop_o, 0);
    @(negedge clk_i); rd_i = 0;
  endtask

  task automatic t_dlab;
    logic [7:0] d; logic p;
    do_write(3'd3, 8'h80);
    do_write(3'd0, 8'h34); check("R2 no push in divisor mode", last_push, 0);
    do_write(3'd1, 8'h12);
    do_read(3'd0, d, p); check("R2 divisor low readback", d, 8'h34);
    check("R2 no pop in divisor mode", p, 0);
    do_read(3'd1, d, p); check("R2 divisor high readback", d, 8'h12);
    do_write(3'd3, 8'h03);
    do_read(3'd1, d, p); check("R2 enable field untouched", d, 8'h0F);
    do_read(3'd0, d, p); check("R2 data port restored", d, 8'hA5);
  endtask

  task automatic t_fifo;
    do_write(3'd2, 8'hC9);
    check("R5 fifo enable", fifo_en_o, 1);
    check("R5 dma mode", dma_mode_o, 1);
    check("R5 trigger 14", rx_trig_level_o, 14);
    check("R6 no rx reset without bit", rx_fifo_rst_o, 0);
    do_write(3'd2, 8'h47);
    check("R6 rx reset pulse", rx_fifo_rst_o, 1);
    check("R6 tx reset pulse", tx_fifo_rst_o, 1);
    check("R5 trigger 4", rx_trig_level_o, 4);
    check("R5 dma cleared", dma_mode_o, 0);
    @(negedge clk_i);
    check("R6 rx reset self-clears", rx_fifo_rst_o, 0);
    check("R6 tx reset self-clears", tx_fifo_rst_o, 0);
    do_write(3'd2, 8'h85);
    check("R6 tx only pulse", {rx_fifo_rst_o, tx_fifo_rst_o}, 2'b01);
    check("R5 trigger 8", rx_trig_level_o, 8);
    do_write(3'd2, 8'h00);
    check("R5 trigger 1", rx_trig_level_o, 1);
    check("R5 fifo disabled", fifo_en_o, 0);
  endtask

  task automatic t_baud;
    do_write(3'd3, 8'h80);
    do_write(3'd1, 8'h00);
    do_write(3'd0, 8'h05);
    check("R7 no tick at reload", baud_tick_o, 0);
    for (int c = 1; c <= 12; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      check("R7 tick cadence div5", baud_tick_o, (c % 5 == 0) ? 1 : 0);
    end
    do_write(3'd0, 8'h01);
    for (int c = 1; c <= 4; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      check("R7 tick every cycle div1", baud_tick_o, 1);
    end
    do_write(3'd0, 8'h00);
    for (int c = 1; c <= 20; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      check("R8 zero divisor silent", baud_tick_o, 0);
    end
    do_write(3'd3, 8'h03);
  endtask

  task automatic t_status;
    logic [7:0] d; logic p;
    rx_empty_i = 0; tx_hold_empty_i = 0; tx_idle_i = 0; rx_fifo_err_i = 1;
    pulse_evt(4'b0011);
    do_read(3'd5, d, p); check("R9 status with overrun and parity", d, 8'h87);
    do_read(3'd5, d, p); check("R10 flags cleared by read", d, 8'h81);
    @(negedge clk_i);
    cs_i = 1; rd_i = 1; addr_i = 3'd5; rx_ferr_i = 1; rx_brk_i = 1;
    #1; d = rdata_o;
    @(posedge clk_i); @(negedge clk_i);
    cs_i = 0; rd_i = 0; rx_ferr_i = 0; rx_brk_i = 0;
    check("R10 read during event returns old", d, 8'h81);
    do_read(3'd5, d, p); check("R10 event survives read", d, 8'h99);
    do_read(3'd5, d, p); check("R10 cleared again", d, 8'h81);
    rx_empty_i = 1; tx_hold_empty_i = 1; tx_idle_i = 1; rx_fifo_err_i = 0;
    do_read(3'd5, d, p); check("R9 idle status", d, 8'h60);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_map();
    t_line();
    t_ien();
    t_data();
    t_dlab();
    t_fifo();
    t_baud();
    t_status();
    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL R11 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule